// File: doc/BRIEF.md
# Warm-Boot Configuration Command Receiver

This block sits on the receiving end of a 32-bit internal configuration write port. Words arrive with the bits of every byte in reverse order. The block restores normal bit order and waits for a synchronisation word. It then decodes single-word register write packets that target a warm-boot start address register and a command register. When the reprogram command arrives, the block runs a warm reboot. The init and done indicators go low, configuration memory is cleared for a fixed number of cycles, and the block asks the flash side for an image at the stored start address.

The flash side reports the result on a done/error pair. If the update image fails to load, the block retries once at base address zero to load the fallback image. If that also fails, the block halts until the next power-up reset. The warm reboot keeps the stored start address and a status bit that records whether the last boot used the fallback image. All other state, including synchronisation, is dropped.

A power-up reset behaves like a reboot with the start address at zero. Flash reads and memory clearing are modelled as timed handshakes.

Top module: `cfg_warmboot_rx`

## Requirements
- R1: Each port word is taken with bit order reversed inside each of its four bytes: port bit 8*b+i carries decoded bit 8*b+7-i. A word sent without this reversal is not recognised.
- R2: Until the sync word 0xAA995566 (decoded) has been accepted, every other word, including 0xFFFFFFFF fillers and packet headers, is ignored.
- R3: After sync, the no-operation word 0x20000000 and any other unrecognised word have no effect.
- R4: Header 0x30020001 makes the next accepted word the start address. The fetch address of the next primary attempt is {start[23:0], 8'h00}.
- R5: Header 0x30008001 makes the next accepted word a command. Value 0x0000000F starts a reboot: init_n and done are low two clock edges after that word is captured. Any other command value is ignored.
- R6: During a reboot, init_n stays low for CLR_CYCLES cycles. Then init_n rises and fetch_req is raised in the same cycle.
- R7: load_done while fetching ends the boot: done goes high and fetch_req goes low on the next cycle.
- R8: load_error on the primary attempt moves fetch_req, on the next cycle, to address 0. fallback_boot is 1 after a successful fallback load and 0 after a successful primary load.
- R9: load_error on the fallback attempt halts the block. init_n, done and fetch_req stay low until reset.
- R10: The start address and fallback_boot survive a reboot. Reset clears both, and the first fetch after reset is at address 0.
- R11: A reboot drops synchronisation, so a new sync word is needed before any further packet has effect.
- R12: A word is accepted only when cfg_en_n is low, cfg_rd is low and the block is in the running state (done high). All other words are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-up reset |
| cfg_en_n | input | 1 | Active-low port enable |
| cfg_rd | input | 1 | 1 = read cycle, 0 = write cycle |
| cfg_data | input | 32 | Byte-bit-reversed write word |
| load_done | input | 1 | Flash side: image loaded successfully |
| load_error | input | 1 | Flash side: image load failed |
| init_n | output | 1 | Low while clearing or halted |
| done | output | 1 | High while an image is running |
| fetch_req | output | 1 | Image read request, held until answered |
| fetch_addr | output | 32 | Flash byte address of the requested image |
| fallback_boot | output | 1 | Last successful boot used the fallback image |

## Verification
The assertions assume that load_done and load_error only matter while fetch_req is high, and that the flash side answers each request with at most one of them per cycle. The stimulus raises a response only after it has seen fetch_req and holds it for exactly one cycle. The bench drives writes only in the running state, except where a test deliberately sends words into a block that is not synchronised or not accepting. The clear-length assertion counts every low period of init_n. Because of this, each halt is ended only by reset and is never followed by a rise of init_n.

// File: rtl/cfgwb_pkg.sv
// Shared constants and state types for the warm-boot command receiver.
// Assumes the decoded (bit-order-restored) 32-bit word space.
package cfgwb_pkg;
    localparam int unsigned WORD_W = 32;

    localparam logic [WORD_W-1:0] SYNC_WORD  = 32'hAA995566;
    localparam logic [WORD_W-1:0] HDR_START  = 32'h30020001;
    localparam logic [WORD_W-1:0] HDR_CMD    = 32'h30008001;
    localparam logic [WORD_W-1:0] CMD_REPROG = 32'h0000000F;

    // Which register the next accepted word belongs to.
    typedef enum logic [1:0] {
        PEND_NONE  = 2'd0,
        PEND_START = 2'd1,
        PEND_CMD   = 2'd2
    } pend_e;

    // Boot sequencer phases.
    typedef enum logic [1:0] {
        BS_CLEAR = 2'd0,
        BS_FETCH = 2'd1,
        BS_RUN   = 2'd2,
        BS_HALT  = 2'd3
    } boot_e;
endpackage

// File: rtl/cfgwb_unswap.sv
// Restores bit order inside each byte lane of a port word.
// Purely combinational; assumes the word width is a whole number of bytes.
module cfgwb_unswap #(
    parameter int unsigned LANES = 4
) (
    input  logic [8*LANES-1:0] raw,
    output logic [8*LANES-1:0] fixed
);
    // Mirror the bits of every lane.
    for (genvar b = 0; b < LANES; b++) begin : g_lane
        for (genvar i = 0; i < 8; i++) begin : g_bit
            assign fixed[8*b+i] = raw[8*b+7-i];
        end
    end
endmodule

// File: rtl/cfgwb_parser.sv
// Packet parser: waits for sync, then decodes one-word writes to the
// start address and command registers. Emits a one-cycle reprogram pulse.
// Assumes wr_en is already qualified by the port enable and write select.
module cfgwb_parser
    import cfgwb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] word,
    output logic [WORD_W-1:0] start_addr,
    output logic              reprog
);
    logic  synced;
    pend_e pend;

    // Sync tracking, packet state and reprogram pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            synced <= 1'b0;
            pend   <= PEND_NONE;
            reprog <= 1'b0;
        end else begin
            reprog <= 1'b0;
            if (hold) begin
                synced <= 1'b0;
                pend   <= PEND_NONE;
            end else if (wr_en) begin
                if (!synced) begin
                    synced <= (word == SYNC_WORD);
                end else begin
                    unique case (pend)
                        PEND_START: pend <= PEND_NONE;
                        PEND_CMD: begin
                            pend <= PEND_NONE;
                            if (word == CMD_REPROG) begin
                                reprog <= 1'b1;
                                synced <= 1'b0;
                            end
                        end
                        default: begin
                            if (word == HDR_START)
                                pend <= PEND_START;
                            else if (word == HDR_CMD)
                                pend <= PEND_CMD;
                        end
                    endcase
                end
            end
        end
    end

    // Start address register: cleared only by power-up reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            start_addr <= '0;
        else if (!hold && wr_en && synced && pend == PEND_START)
            start_addr <= word;
    end
endmodule

// File: rtl/cfgwb_boot_seq.sv
// Reboot sequencer: clears for CLR_CYCLES, fetches at the start address,
// retries once at base zero on error, halts if the fallback fails too.
// Assumes load_done/load_error are only meaningful while fetching.
module cfgwb_boot_seq
    import cfgwb_pkg::*;
#(
    parameter int unsigned CLR_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reprog,
    input  logic [WORD_W-1:0] start_addr,
    input  logic              load_done,
    input  logic              load_error,
    output logic              init_n,
    output logic              done,
    output logic              fetch_req,
    output logic [WORD_W-1:0] fetch_addr,
    output logic              fallback_boot,
    output logic              running
);
    localparam int unsigned CNT_W = (CLR_CYCLES > 1) ? $clog2(CLR_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLR_CYCLES - 1);

    boot_e            st;
    logic [CNT_W-1:0] cnt;
    logic             use_base;

    // Phase transitions, clear timer, attempt selection and boot status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st            <= BS_CLEAR;
            cnt           <= '0;
            use_base      <= 1'b0;
            fallback_boot <= 1'b0;
        end else begin
            unique case (st)
                BS_CLEAR: begin
                    if (cnt == CNT_LAST) begin
                        st  <= BS_FETCH;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                BS_FETCH: begin
                    if (load_done) begin
                        st            <= BS_RUN;
                        fallback_boot <= use_base;
                    end else if (load_error) begin
                        if (use_base)
                            st <= BS_HALT;
                        else
                            use_base <= 1'b1;
                    end
                end
                BS_RUN: begin
                    if (reprog) begin
                        st       <= BS_CLEAR;
                        cnt      <= '0;
                        use_base <= 1'b0;
                    end
                end
                default: st <= BS_HALT;
            endcase
        end
    end

    // Output decode from the phase.
    always_comb begin
        init_n     = (st == BS_FETCH) || (st == BS_RUN);
        done       = (st == BS_RUN);
        running    = (st == BS_RUN);
        fetch_req  = (st == BS_FETCH);
        fetch_addr = use_base ? '0 : {start_addr[23:0], 8'h00};
    end
endmodule

// File: rtl/cfg_warmboot_rx.sv
// Top of the warm-boot command receiver: bit-order restore, packet parser
// and reboot sequencer. Words are accepted only while an image is running.
module cfg_warmboot_rx #(
    parameter int unsigned CLR_CYCLES = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_en_n,
    input  logic        cfg_rd,
    input  logic [31:0] cfg_data,
    input  logic        load_done,
    input  logic        load_error,
    output logic        init_n,
    output logic        done,
    output logic        fetch_req,
    output logic [31:0] fetch_addr,
    output logic        fallback_boot
);
    logic [31:0] word;
    logic [31:0] start_addr;
    logic        reprog;
    logic        running;
    logic        wr_en;

    // Port write qualifier.
    assign wr_en = !cfg_en_n && !cfg_rd;

    cfgwb_unswap #(.LANES(4)) unswap_i (
        .raw   (cfg_data),
        .fixed (word)
    );

    cfgwb_parser parser_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold       (!running),
        .wr_en      (wr_en),
        .word       (word),
        .start_addr (start_addr),
        .reprog     (reprog)
    );

    cfgwb_boot_seq #(.CLR_CYCLES(CLR_CYCLES)) seq_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .reprog        (reprog),
        .start_addr    (start_addr),
        .load_done     (load_done),
        .load_error    (load_error),
        .init_n        (init_n),
        .done          (done),
        .fetch_req     (fetch_req),
        .fetch_addr    (fetch_addr),
        .fallback_boot (fallback_boot),
        .running       (running)
    );
endmodule

// File: rtl/cfg_warmboot_rx_chk.sv
// Port-level checker for the warm-boot receiver, bound to the top.
// Assumes the flash side answers only while fetch_req is high.
module cfg_warmboot_rx_chk #(
    parameter int unsigned CLR_CYCLES = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        init_n,
    input logic        done,
    input logic        fetch_req,
    input logic [31:0] fetch_addr,
    input logic        load_error,
    input logic        fallback_boot
);
    logic [31:0] low_cnt;

    // Length of the current init_n low period.
    always_ff @(posedge clk) begin
        if (!rst_n)
            low_cnt <= '0;
        else if (!init_n)
            low_cnt <= low_cnt + 1'b1;
        else
            low_cnt <= '0;
    end

    assert_clear_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_n) |-> (low_cnt == CLR_CYCLES) && fetch_req);

    assert_fetch_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |-> init_n && !done);

    assert_run_phase_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> init_n && !fetch_req);

    assert_reboot_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done) |-> !init_n);

    assert_retry_base_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && load_error && fetch_addr != 32'h0) |=> fetch_req && (fetch_addr == 32'h0));

    assert_status_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fallback_boot) |-> $rose(done));
endmodule

bind cfg_warmboot_rx cfg_warmboot_rx_chk #(.CLR_CYCLES(CLR_CYCLES)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .init_n        (init_n),
    .done          (done),
    .fetch_req     (fetch_req),
    .fetch_addr    (fetch_addr),
    .load_error    (load_error),
    .fallback_boot (fallback_boot)
);

// File: tb/cfg_warmboot_rx_tb_top.sv
module cfg_warmboot_rx_tb_top;
    localparam int CLR = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_en_n = 1'b1;
    logic        cfg_rd = 1'b1;
    logic [31:0] cfg_data = '0;
    logic        load_done = 1'b0;
    logic        load_error = 1'b0;
    logic        init_n, done, fetch_req, fallback_boot;
    logic [31:0] fetch_addr;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    cfg_warmboot_rx #(.CLR_CYCLES(CLR)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_en_n(cfg_en_n), .cfg_rd(cfg_rd),
        .cfg_data(cfg_data), .load_done(load_done), .load_error(load_error),
        .init_n(init_n), .done(done), .fetch_req(fetch_req),
        .fetch_addr(fetch_addr), .fallback_boot(fallback_boot)
    );

    // {start address, primary fails, expected primary fetch address}
    localparam logic [64:0] VEC [4] = '{
        {32'h00400000, 1'b0, 32'h40000000},
        {32'h12345678, 1'b1, 32'h34567800},
        {32'hFF000100, 1'b0, 32'h00010000},
        {32'h00ABCD00, 1'b1, 32'hABCD0000}
    };

    function automatic logic [31:0] rev_bytes(input logic [31:0] w);
        logic [31:0] r;
        for (int b = 0; b < 4; b++)
            for (int i = 0; i < 8; i++)
                r[8*b+i] = w[8*b+7-i];
        return r;
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Send one word; rd/en selectable, swap optional.
    task automatic put(input logic [31:0] w, input logic en_n, input logic rd, input logic swap);
        cfg_data = swap ? rev_bytes(w) : w;
        cfg_en_n = en_n;
        cfg_rd   = rd;
        tick();
        cfg_en_n = 1'b1;
        cfg_rd   = 1'b1;
    endtask

    task automatic send(input logic [31:0] w);
        put(w, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic reprog_cmd();
        send(32'h30008001);
        send(32'h0000000F);
        tick();
    endtask

    // Count cycles until fetch_req rises (bounded).
    task automatic wait_fetch(output int n);
        n = 0;
        while (!fetch_req && n < 100) begin
            tick();
            n++;
        end
    endtask

    task automatic answer(input logic err);
        if (err) load_error = 1'b1; else load_done = 1'b1;
        tick();
        load_error = 1'b0;
        load_done  = 1'b0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
        $finish;
    end

    initial begin
        int n;
        logic exp_fb;
        repeat (3) tick();
        // Reset state
        check("R10 reset init_n", {31'd0, init_n}, 32'd0);
        check("R10 reset done", {31'd0, done}, 32'd0);
        check("R10 reset fallback", {31'd0, fallback_boot}, 32'd0);
        rst_n = 1'b1;
        wait_fetch(n);
        check("R6 power-up clear length", n, CLR);
        check("R10 power-up fetch at 0", fetch_addr, 32'h0);
        answer(1'b0);
        check("R7 done after load", {30'd0, done, fetch_req}, 32'd2);

        // Vector loop: program start address, reprogram, answer.
        exp_fb = 1'b0;
        foreach (VEC[k]) begin
            send(32'hFFFFFFFF);
            send(32'hAA995566);
            send(32'h20000000);
            send(32'h30020001);
            send(VEC[k][64:33]);
            send(32'h20000000);
            reprog_cmd();
            check("R5 reboot drops done/init_n", {30'd0, done, init_n}, 32'd0);
            check("R10 fallback kept across reboot", {31'd0, fallback_boot}, {31'd0, exp_fb});
            wait_fetch(n);
            check("R6 clear length", n, CLR);
            check("R4 fetch address", fetch_addr, VEC[k][31:0]);
            if (VEC[k][32]) begin
                answer(1'b1);
                check("R8 retry request", {31'd0, fetch_req}, 32'd1);
                check("R8 retry at base", fetch_addr, 32'h0);
            end
            answer(1'b0);
            exp_fb = VEC[k][32];
            check("R7 done after load", {30'd0, done, fetch_req}, 32'd2);
            check("R8 fallback status", {31'd0, fallback_boot}, {31'd0, exp_fb});
        end

        // R11: after reboot, no sync -> reprogram ignored
        reprog_cmd();
        tick();
        check("R11 unsynced command ignored", {31'd0, done}, 32'd1);

        // R1/R2: sync sent without bit reversal is not recognised
        put(32'hAA995566, 1'b0, 1'b0, 1'b0);
        reprog_cmd();
        tick();
        check("R1 unswapped sync ignored", {31'd0, done}, 32'd1);

        // R2: dummies and headers before sync ignored
        send(32'hFFFFFFFF);
        send(32'h30020001);
        send(32'h00000001);
        reprog_cmd();
        tick();
        check("R2 pre-sync packets ignored", {31'd0, done}, 32'd1);

        // R5: other command value ignored; R3 unknown word ignored
        send(32'hAA995566);
        send(32'h12345678);
        send(32'h30008001);
        send(32'h00000007);
        tick();
        check("R5 non-reprogram command ignored", {31'd0, done}, 32'd1);

        // R12: writes with read select or enable high ignored
        put(32'h30020001, 1'b0, 1'b1, 1'b1);
        put(32'h00777700, 1'b0, 1'b1, 1'b1);
        put(32'h30020001, 1'b1, 1'b0, 1'b1);
        put(32'h00555500, 1'b1, 1'b0, 1'b1);
        send(32'h20000000);
        reprog_cmd();
        wait_fetch(n);
        check("R12 ignored writes keep start address", fetch_addr, 32'hABCD0000);
        // R12: word during fetch is not accepted (sync then command would reboot)
        send(32'hAA995566);
        answer(1'b0);
        check("R8 primary success clears status", {31'd0, fallback_boot}, 32'd0);
        reprog_cmd();
        tick();
        check("R12 words outside run ignored", {31'd0, done}, 32'd1);

        // R9: both attempts fail -> halt
        send(32'hAA995566);
        reprog_cmd();
        wait_fetch(n);
        answer(1'b1);
        answer(1'b1);
        repeat (CLR + 4) tick();
        check("R9 halt", {29'd0, init_n, done, fetch_req}, 32'd0);

        // R10: reset clears start address and status
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        wait_fetch(n);
        check("R10 fetch at 0 after reset", fetch_addr, 32'h0);
        check("R10 status cleared", {31'd0, fallback_boot}, 32'd0);
        answer(1'b0);

        summary();
        $finish;
    end
endmodule